// File: doc/BRIEF.md
# Way-Partitioned Set-Associative Cache

This block is a four-way set-associative data cache with 32-byte lines. It sits between a simple line-granular request bus and a main-memory port that carries refills, evictions and uncached traffic. Any subset of the four ways can be taken out of cache duty by a configuration mask and used as directly addressed on-chip memory. Accesses that decode into that memory window read or write the reserved way's data array at a fixed latency. The other ways keep working as a cache with reduced capacity and associativity.

Every request carries an allocate-on-miss flag. A miss with the flag set picks a victim among the ways still in cache duty and refills into it. A miss with the flag clear is served through the memory port and leaves the arrays untouched. The cache keeps no record of what any upper-level cache holds. A change of the partition mask is applied only while the block is idle. Before the change, every dirty line in a way that changes role is written back and invalidated.

Top module: `way_part_cache`

## Requirements
- R1: A read that hits a valid line in a cache-duty way returns the line on `rsp_rdata` with `rsp_valid` high in the cycle right after acceptance, and no memory-port transaction takes place.
- R2: Every read outside the window returns the most recent data written to that line. This holds whatever mix of hits, misses, evictions and bypasses came before. `req_be[i]` enables byte i, which is bits 8i+7 down to 8i of the line.
- R3: On a miss with `req_alloc`=1, the line is refilled from memory and installed, and a following read of it hits. On a miss with `req_alloc`=0, a read is served from memory and is not installed, so a repeat read also goes to memory. A write miss with `req_alloc`=0 is forwarded with its byte enables.
- R4: Once `mem_req` is raised, it stays high with a stable `mem_addr` until a cycle in which `mem_ack` is high.
- R5: A request is in the memory window when `req_addr[ADDR_W-1:11]` equals `cfg_win_base` and the way numbered by `req_addr[10:9]` is reserved in the active mask. `req_addr[8:5]` selects the entry. The response follows one cycle after acceptance, with no memory-port transaction.
- R6: A window write whose byte enables are not all ones is dropped and sets `err_sticky`. That bit then stays high until reset.
- R7: Replacement never selects a reserved way, so window contents survive any amount of cache traffic.
- R8: A new value of `cfg_way_mem` is applied only from idle. `req_ready` stays low until the change is complete. Dirty lines in every way that changes role are written back to memory first.
- R9: With all four ways reserved, every request outside the window goes to the memory port.
- R10: After reset, `req_ready` is high when `cfg_way_mem` is zero, and `rsp_valid`, `mem_req` and `err_sticky` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this edge if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_alloc | input | 1 | Allocate a line on a miss |
| req_addr | input | ADDR_W | Byte address of the line |
| req_be | input | 32 | Byte enables for writes |
| req_wdata | input | 256 | Write line data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 256 | Read line data (zero for writes) |
| mem_req | output | 1 | Memory transaction pending |
| mem_write | output | 1 | Memory transaction is a write |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_be | output | 32 | Memory write byte enables |
| mem_wdata | output | 256 | Memory write data |
| mem_ack | input | 1 | Memory transaction done, read data valid |
| mem_rdata | input | 256 | Memory read data |
| cfg_way_mem | input | 4 | Ways reserved as memory (bit per way) |
| cfg_win_base | input | ADDR_W-11 | Upper address bits of the window |
| err_sticky | output | 1 | Partial window write seen |

## Verification
Directed patterns come first. The block is tried with a write-then-read of one line, which separates a hit from a refill. It is then tried with repeated reads with the allocate flag clear, which separates bypass from install. Next comes a partial write through the bypass path, then full and partial window writes, which separate a bank write from a dropped one. Random traffic is then confined to two sets with eight tags each. Under one reserved way this forces constant eviction of dirty lines, while window reads check that the reserved way is never picked. A final switch to all ways reserved is followed by a comparison of the whole of main memory with the expected image, which shows whether the role-change flush missed any dirty line.

// File: rtl/wpc_pkg.sv
package wpc_pkg;
  localparam int NWAYS      = 4;
  localparam int LINE_BYTES = 32;
  localparam int LINE_BITS  = LINE_BYTES * 8;
  localparam int OFF_W      = $clog2(LINE_BYTES);
  localparam int WAY_W      = $clog2(NWAYS);

  typedef logic [LINE_BITS-1:0]  line_t;
  typedef logic [LINE_BYTES-1:0] be_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_EVICT, ST_FILL, ST_BYPASS, ST_SCAN, ST_SCANWB
  } st_e;

  // byte-wise merge of new data into an old line
  function automatic line_t merge_bytes(line_t old_l, line_t new_l, be_t be);
    line_t res;
    res = old_l;
    for (int b = 0; b < LINE_BYTES; b++)
      if (be[b]) res[b*8 +: 8] = new_l[b*8 +: 8];
    return res;
  endfunction

  // tree bits: [0]=victim in upper pair, [1]=victim way1, [2]=victim way3
  function automatic logic [2:0] plru_touch(logic [2:0] t, logic [WAY_W-1:0] w);
    logic [2:0] n;
    n = t;
    if (!w[1]) begin
      n[0] = 1'b1;
      n[1] = (w == 2'd0);
    end else begin
      n[0] = 1'b0;
      n[2] = (w == 2'd2);
    end
    return n;
  endfunction
endpackage

// File: rtl/wpc_tag_match.sv
module wpc_tag_match import wpc_pkg::*; #(
  parameter int TAG_W = 23
) (
  input  logic [NWAYS-1:0][TAG_W-1:0] tags,
  input  logic [NWAYS-1:0]            valid,
  input  logic [NWAYS-1:0]            usable,
  input  logic [TAG_W-1:0]            look_tag,
  output logic                        hit,
  output logic [WAY_W-1:0]            hit_way
);
  logic [NWAYS-1:0] hit_vec;

  for (genvar g = 0; g < NWAYS; g++) begin : g_cmp
    assign hit_vec[g] = valid[g] & usable[g] & (tags[g] == look_tag);
  end

  always_comb begin
    hit     = |hit_vec;
    hit_way = '0;
    for (int i = NWAYS-1; i >= 0; i--)
      if (hit_vec[i]) hit_way = WAY_W'(i);
  end
endmodule

// File: rtl/wpc_victim.sv
module wpc_victim import wpc_pkg::*; (
  input  logic [2:0]       tree,
  input  logic [NWAYS-1:0] usable,
  input  logic [NWAYS-1:0] valid,
  output logic             found,
  output logic [WAY_W-1:0] way
);
  logic [NWAYS-1:0] empty;
  logic lo_ok, hi_ok, go_hi;

  always_comb begin
    empty = usable & ~valid;
    found = |usable;
    lo_ok = usable[0] | usable[1];
    hi_ok = usable[2] | usable[3];
    go_hi = hi_ok && (!lo_ok || tree[0]);
    way   = '0;
    if (|empty) begin
      for (int i = NWAYS-1; i >= 0; i--)
        if (empty[i]) way = WAY_W'(i);
    end else if (go_hi) begin
      if (usable[2] && usable[3]) way = tree[2] ? 2'd3 : 2'd2;
      else                        way = usable[3] ? 2'd3 : 2'd2;
    end else begin
      if (usable[0] && usable[1]) way = tree[1] ? 2'd1 : 2'd0;
      else                        way = usable[1] ? 2'd1 : 2'd0;
    end
  end
endmodule

// File: rtl/wpc_win_decode.sv
module wpc_win_decode import wpc_pkg::*; #(
  parameter int BASE_W = 21
) (
  input  logic [BASE_W-1:0] hi_bits,
  input  logic [BASE_W-1:0] base,
  input  logic [WAY_W-1:0]  way_bits,
  input  logic [NWAYS-1:0]  reserved,
  output logic              in_win
);
  assign in_win = (hi_bits == base) && reserved[way_bits];
endmodule

// File: rtl/way_part_cache.sv
module way_part_cache import wpc_pkg::*; #(
  parameter  int ADDR_W   = 32,
  parameter  int NUM_SETS = 16,
  localparam int SET_W    = $clog2(NUM_SETS),
  localparam int TAG_W    = ADDR_W - OFF_W - SET_W,
  localparam int WIN_LSB  = OFF_W + SET_W + WAY_W,
  localparam int BASE_W   = ADDR_W - WIN_LSB,
  localparam int SCAN_W   = SET_W + WAY_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_write,
  input  logic                  req_alloc,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [LINE_BYTES-1:0] req_be,
  input  logic [LINE_BITS-1:0]  req_wdata,
  output logic                  rsp_valid,
  output logic [LINE_BITS-1:0]  rsp_rdata,
  output logic                  mem_req,
  output logic                  mem_write,
  output logic [ADDR_W-1:0]     mem_addr,
  output logic [LINE_BYTES-1:0] mem_be,
  output logic [LINE_BITS-1:0]  mem_wdata,
  input  logic                  mem_ack,
  input  logic [LINE_BITS-1:0]  mem_rdata,
  input  logic [NWAYS-1:0]      cfg_way_mem,
  input  logic [BASE_W-1:0]     cfg_win_base,
  output logic                  err_sticky
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rsync_q;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_ni = rsync_q[1];

  // storage
  logic [TAG_W-1:0] tag_q  [NWAYS][NUM_SETS];
  line_t            data_q [NWAYS][NUM_SETS];
  logic [NWAYS-1:0] vld_q  [NUM_SETS];
  logic [NWAYS-1:0] dty_q  [NUM_SETS];
  logic [2:0]       plru_q [NUM_SETS];

  // control state
  st_e              st_q, st_d;
  logic [NWAYS-1:0] act_mask_q, act_d, new_mask_q, newm_d;
  logic [SCAN_W-1:0] scan_q, scan_d;
  logic             rsp_v_q, rspv_d, err_q, err_d;
  line_t            rsp_d_q, rspd_d;
  logic             cap_en;
  logic [ADDR_W-1:0] rq_addr_q;
  logic             rq_write_q;
  be_t              rq_be_q;
  line_t            rq_wdata_q;
  logic [WAY_W-1:0] vway_q, vway_d;

  // array write port
  logic             lw_en, lw_vld, lw_dty, pl_en;
  logic [WAY_W-1:0] lw_way, pl_way;
  logic [TAG_W-1:0] lw_tag;
  line_t            lw_data;

  // address slices
  logic [SET_W-1:0] req_set, rq_set, scan_set, lk_set;
  logic [TAG_W-1:0] req_tag, rq_tag;
  logic [WAY_W-1:0] req_wsel, scan_way;

  assign req_set  = req_addr[OFF_W +: SET_W];
  assign req_tag  = req_addr[ADDR_W-1 -: TAG_W];
  assign req_wsel = req_addr[OFF_W+SET_W +: WAY_W];
  assign rq_set   = rq_addr_q[OFF_W +: SET_W];
  assign rq_tag   = rq_addr_q[ADDR_W-1 -: TAG_W];
  assign scan_set = scan_q[SCAN_W-1:WAY_W];
  assign scan_way = scan_q[WAY_W-1:0];

  always_comb begin
    if (st_q == ST_IDLE)                               lk_set = req_set;
    else if (st_q == ST_SCAN || st_q == ST_SCANWB)     lk_set = scan_set;
    else                                               lk_set = rq_set;
  end

  // per-set views
  logic [NWAYS-1:0][TAG_W-1:0] set_tags;
  logic [NWAYS-1:0]            set_vld, set_dty, usable, chg_mask;
  for (genvar g = 0; g < NWAYS; g++) begin : g_view
    assign set_tags[g] = tag_q[g][lk_set];
  end
  assign set_vld  = vld_q[lk_set];
  assign set_dty  = dty_q[lk_set];
  assign usable   = ~act_mask_q;
  assign chg_mask = act_mask_q ^ new_mask_q;

  logic             hit, vic_found, in_win;
  logic [WAY_W-1:0] hit_way, vic_way;

  wpc_tag_match #(.TAG_W(TAG_W)) i_match (
    .tags(set_tags), .valid(set_vld), .usable(usable),
    .look_tag(req_tag), .hit(hit), .hit_way(hit_way)
  );

  wpc_victim i_victim (
    .tree(plru_q[lk_set]), .usable(usable), .valid(set_vld),
    .found(vic_found), .way(vic_way)
  );

  wpc_win_decode #(.BASE_W(BASE_W)) i_win (
    .hi_bits(req_addr[ADDR_W-1 -: BASE_W]), .base(cfg_win_base),
    .way_bits(req_wsel), .reserved(act_mask_q), .in_win(in_win)
  );

  assign req_ready = (st_q == ST_IDLE) && (cfg_way_mem == act_mask_q);

  line_t fill_line;
  assign fill_line = rq_write_q ? merge_bytes(mem_rdata, rq_wdata_q, rq_be_q) : mem_rdata;

  // next-state logic
  always_comb begin
    st_d = st_q; act_d = act_mask_q; newm_d = new_mask_q; scan_d = scan_q;
    rspv_d = 1'b0; rspd_d = rsp_d_q; err_d = err_q;
    cap_en = 1'b0; vway_d = vway_q;
    lw_en = 1'b0; lw_way = '0; lw_tag = req_tag; lw_vld = 1'b0; lw_dty = 1'b0;
    lw_data = '0; pl_en = 1'b0; pl_way = '0;
    mem_req = 1'b0; mem_write = 1'b0; mem_be = '1; mem_wdata = rq_wdata_q;
    mem_addr = {rq_addr_q[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
    case (st_q)
      ST_IDLE: begin
        if (cfg_way_mem != act_mask_q) begin
          newm_d = cfg_way_mem;
          scan_d = '0;
          st_d   = ST_SCAN;
        end else if (req_valid) begin
          cap_en = 1'b1;
          if (in_win) begin
            rspv_d = 1'b1;
            rspd_d = req_write ? '0 : data_q[req_wsel][lk_set];
            if (req_write && (&req_be)) begin
              lw_en = 1'b1; lw_way = req_wsel; lw_data = req_wdata;
            end else if (req_write) begin
              err_d = 1'b1;
            end
          end else if (hit) begin
            rspv_d  = 1'b1;
            rspd_d  = req_write ? '0 : data_q[hit_way][lk_set];
            lw_en   = 1'b1; lw_way = hit_way; lw_vld = 1'b1;
            lw_dty  = set_dty[hit_way] | req_write;
            lw_data = merge_bytes(data_q[hit_way][lk_set], req_wdata,
                                  req_write ? req_be : '0);
            pl_en   = 1'b1; pl_way = hit_way;
          end else if (req_alloc && vic_found) begin
            vway_d = vic_way;
            st_d   = (set_vld[vic_way] && set_dty[vic_way]) ? ST_EVICT : ST_FILL;
          end else begin
            st_d = ST_BYPASS;
          end
        end
      end
      ST_EVICT: begin
        mem_req   = 1'b1; mem_write = 1'b1;
        mem_addr  = {set_tags[vway_q], lk_set, {OFF_W{1'b0}}};
        mem_wdata = data_q[vway_q][lk_set];
        if (mem_ack) st_d = ST_FILL;
      end
      ST_FILL: begin
        mem_req = 1'b1;
        if (mem_ack) begin
          lw_en = 1'b1; lw_way = vway_q; lw_tag = rq_tag; lw_vld = 1'b1;
          lw_dty = rq_write_q; lw_data = fill_line;
          pl_en = 1'b1; pl_way = vway_q;
          rspv_d = 1'b1; rspd_d = rq_write_q ? '0 : mem_rdata;
          st_d = ST_IDLE;
        end
      end
      ST_BYPASS: begin
        mem_req = 1'b1; mem_write = rq_write_q; mem_addr = rq_addr_q;
        mem_be = rq_write_q ? rq_be_q : '1;
        if (mem_ack) begin
          rspv_d = 1'b1; rspd_d = rq_write_q ? '0 : mem_rdata;
          st_d = ST_IDLE;
        end
      end
      ST_SCAN, ST_SCANWB: begin
        if (st_q == ST_SCANWB) begin
          mem_req   = 1'b1; mem_write = 1'b1;
          mem_addr  = {set_tags[scan_way], lk_set, {OFF_W{1'b0}}};
          mem_wdata = data_q[scan_way][lk_set];
        end
        if (st_q == ST_SCAN && chg_mask[scan_way] && set_vld[scan_way] && set_dty[scan_way]) begin
          st_d = ST_SCANWB;
        end else if (st_q == ST_SCAN || mem_ack) begin
          if (chg_mask[scan_way]) begin
            lw_en = 1'b1; lw_way = scan_way; lw_tag = set_tags[scan_way];
            lw_data = data_q[scan_way][lk_set];
          end
          if (scan_q == '1) begin
            act_d = new_mask_q; st_d = ST_IDLE;
          end else begin
            scan_d = scan_q + 1'b1; st_d = ST_SCAN;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // control registers
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE; act_mask_q <= '0; new_mask_q <= '0; scan_q <= '0;
      rsp_v_q <= 1'b0; err_q <= 1'b0;
    end else begin
      st_q <= st_d; act_mask_q <= act_d; new_mask_q <= newm_d; scan_q <= scan_d;
      rsp_v_q <= rspv_d; err_q <= err_d;
    end
  end

  // datapath registers with explicit enables
  always_ff @(posedge clk) begin
    if (cap_en) begin
      rq_addr_q <= req_addr; rq_write_q <= req_write;
      rq_be_q <= req_be; rq_wdata_q <= req_wdata; vway_q <= vway_d;
    end
    if (rspv_d) rsp_d_q <= rspd_d;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < NUM_SETS; s++) begin
        vld_q[s] <= '0; dty_q[s] <= '0; plru_q[s] <= '0;
      end
    end else begin
      if (lw_en) begin
        vld_q[lk_set][lw_way] <= lw_vld;
        dty_q[lk_set][lw_way] <= lw_dty;
      end
      if (pl_en) plru_q[lk_set] <= plru_touch(plru_q[lk_set], pl_way);
    end
  end

  always_ff @(posedge clk) begin
    if (lw_en) begin
      tag_q[lw_way][lk_set]  <= lw_tag;
      data_q[lw_way][lk_set] <= lw_data;
    end
  end

  assign rsp_valid  = rsp_v_q;
  assign rsp_rdata  = rsp_d_q;
  assign err_sticky = err_q;
endmodule

// File: rtl/wpc_checker.sv
module wpc_checker import wpc_pkg::*; #(
  parameter int ADDR_W  = 32,
  parameter int WIN_LSB = 11
) (
  input logic                        clk,
  input logic                        rst_ni,
  input logic                        req_valid,
  input logic                        req_ready,
  input logic                        req_write,
  input logic [ADDR_W-1:0]           req_addr,
  input logic [LINE_BYTES-1:0]       req_be,
  input logic [ADDR_W-WIN_LSB-1:0]   cfg_win_base,
  input logic [NWAYS-1:0]            cfg_way_mem,
  input logic [NWAYS-1:0]            act_mask,
  input logic                        rsp_valid,
  input logic                        mem_req,
  input logic                        mem_ack,
  input logic [ADDR_W-1:0]           mem_addr,
  input logic                        err_sticky
);
  logic acc, win_sel;
  assign acc     = req_valid && req_ready;
  assign win_sel = (req_addr[ADDR_W-1:WIN_LSB] == cfg_win_base)
                   && act_mask[req_addr[WIN_LSB-1 -: WAY_W]];

  AST_WIN_FIXED_LAT: assert property (@(posedge clk) disable iff (!rst_ni)
    acc && win_sel |=> rsp_valid && !mem_req); // R5
  AST_WIN_PARTIAL_ERR: assert property (@(posedge clk) disable iff (!rst_ni)
    acc && win_sel && req_write && !(&req_be) |=> err_sticky); // R6
  AST_ERR_HOLDS: assert property (@(posedge clk) disable iff (!rst_ni)
    err_sticky |=> err_sticky); // R6
  AST_CFG_BLOCKS_REQ: assert property (@(posedge clk) disable iff (!rst_ni)
    (cfg_way_mem != act_mask) |-> !req_ready); // R8
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_ni)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr)); // R4
  AST_ALL_RESERVED_MISS: assert property (@(posedge clk) disable iff (!rst_ni)
    acc && !win_sel && (&act_mask) |=> mem_req); // R9
endmodule

bind way_part_cache wpc_checker #(.ADDR_W(ADDR_W), .WIN_LSB(WIN_LSB)) i_wpc_checker (
  .clk(clk), .rst_ni(rst_ni), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_addr(req_addr), .req_be(req_be),
  .cfg_win_base(cfg_win_base), .cfg_way_mem(cfg_way_mem), .act_mask(act_mask_q),
  .rsp_valid(rsp_valid), .mem_req(mem_req), .mem_ack(mem_ack),
  .mem_addr(mem_addr), .err_sticky(err_sticky)
);

// File: tb/test_way_part_cache.sv
module test_way_part_cache;
  timeunit 1ns; timeprecision 1ps;

  logic clk, rst_n;
  logic req_valid, req_ready, req_write, req_alloc;
  logic [31:0] req_addr, req_be, mem_addr, mem_be;
  logic [255:0] req_wdata, rsp_rdata, mem_wdata, mem_rdata;
  logic rsp_valid, mem_req, mem_write, mem_ack, err_sticky;
  logic [3:0] cfg_way_mem;
  logic [20:0] cfg_win_base;

  way_part_cache i_way_part_cache (.*);

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int n_tests = 0, n_fail = 0, mem_cnt = 0;
  logic [255:0] mm [128];
  logic [255:0] gold [128];
  logic [255:0] wgold [4][16];
  bit wvalid [4][16];

  task automatic chk(input string tag, input logic [255:0] act, input logic [255:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [255:0] rline();
    logic [255:0] l;
    for (int k = 0; k < 8; k++) l[k*32 +: 32] = $urandom;
    return l;
  endfunction

  function automatic logic [255:0] bmerge(logic [255:0] o, logic [255:0] n, logic [31:0] be);
    logic [255:0] r = o;
    for (int b = 0; b < 32; b++) if (be[b]) r[b*8 +: 8] = n[b*8 +: 8];
    return r;
  endfunction

  function automatic logic [31:0] caddr(int idx);
    return 32'(idx) << 5;
  endfunction

  function automatic logic [31:0] waddr(int way, int set);
    return 32'h10000 | (32'(way) << 9) | (32'(set) << 5);
  endfunction

  // main-memory model: acks after a short wait
  initial begin
    int dly = 0;
    mem_ack = 1'b0; mem_rdata = '0;
    forever begin
      @(negedge clk);
      if (mem_ack) mem_ack = 1'b0;
      else if (mem_req) begin
        if (dly == 2) begin
          dly = 0; mem_ack = 1'b1; mem_cnt++;
          if (mem_write) mm[mem_addr[11:5]] = bmerge(mm[mem_addr[11:5]], mem_wdata, mem_be);
          else mem_rdata = mm[mem_addr[11:5]];
        end else dly++;
      end
    end
  end

  task automatic do_req(input bit wr, input bit al, input logic [31:0] a, input logic [31:0] be,
                        input logic [255:0] wd, output logic [255:0] rd, output int lat, output int nm);
    int m0;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_alloc = al; req_addr = a; req_be = be; req_wdata = wd;
    while (!req_ready) @(negedge clk);
    m0 = mem_cnt;
    @(negedge clk);
    req_valid = 1'b0; lat = 1;
    while (!rsp_valid && lat < 2000) begin @(negedge clk); lat++; end
    rd = rsp_rdata; nm = mem_cnt - m0;
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    summary();
  end

  initial begin
    logic [255:0] rd, d;
    int lat, nm;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 128; i++) begin mm[i] = rline(); gold[i] = mm[i]; end
    for (int w = 0; w < 4; w++) for (int s = 0; s < 16; s++) wvalid[w][s] = 1'b0;
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_alloc = 1'b0;
    req_addr = '0; req_be = '0; req_wdata = '0;
    cfg_way_mem = 4'b0000; cfg_win_base = 21'd32;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10 reset state
    chk("R10 req_ready", req_ready, 1);
    chk("R10 rsp_valid", rsp_valid, 0);
    chk("R10 mem_req", mem_req, 0);
    chk("R10 err_sticky", err_sticky, 0);

    // R3 allocating write miss, then R1 hit
    d = rline();
    do_req(1, 1, caddr(16), 32'hFFFF_FFFF, d, rd, lat, nm);
    gold[16] = d;
    chk("R3 alloc write miss uses memory", nm > 0, 1);
    do_req(0, 1, caddr(16), '0, '0, rd, lat, nm);
    chk("R1 hit data", rd, gold[16]);
    chk("R1 hit latency", lat, 1);
    chk("R1 hit no memory traffic", nm, 0);

    // R3 non-allocating reads
    do_req(0, 0, caddr(33), '0, '0, rd, lat, nm);
    chk("R3 bypass read data", rd, gold[33]);
    do_req(0, 0, caddr(33), '0, '0, rd, lat, nm);
    chk("R3 bypass repeat still misses", nm > 0, 1);

    // R3 non-allocating partial write forwarded
    d = rline();
    do_req(1, 0, caddr(34), 32'h0000_FFFF, d, rd, lat, nm);
    gold[34] = bmerge(gold[34], d, 32'h0000_FFFF);
    chk("R3 bypass write reaches memory", mm[34], gold[34]);

    // reserve way 3
    cfg_way_mem = 4'b1000;
    d = rline();
    do_req(1, 0, waddr(3, 5), 32'hFFFF_FFFF, d, rd, lat, nm);
    wgold[3][5] = d; wvalid[3][5] = 1'b1;
    chk("R5 window write latency", lat, 1);
    chk("R5 window write no memory", nm, 0);
    do_req(0, 0, waddr(3, 5), '0, '0, rd, lat, nm);
    chk("R5 window read data", rd, wgold[3][5]);
    chk("R5 window read latency", lat, 1);

    // R6 partial window write dropped
    do_req(1, 0, waddr(3, 5), 32'h0000_00FF, rline(), rd, lat, nm);
    chk("R6 err set", err_sticky, 1);
    do_req(0, 0, waddr(3, 5), '0, '0, rd, lat, nm);
    chk("R6 partial write dropped", rd, wgold[3][5]);

    // random phase: thrash two sets, interleave window traffic
    for (int it = 0; it < 400; it++) begin
      int sel = $urandom % 10;
      if (sel < 7) begin
        int idx = (($urandom % 8) << 4) | ($urandom % 2);
        bit wr = $urandom % 2;
        bit al = $urandom % 2;
        logic [31:0] be = ($urandom % 2) ? 32'hFFFF_FFFF : $urandom;
        d = rline();
        do_req(wr, al, caddr(idx), be, d, rd, lat, nm);
        if (wr) gold[idx] = bmerge(gold[idx], d, be);
        else chk("R2 cached read data", rd, gold[idx]);
      end else begin
        int s = $urandom % 16;
        int op = $urandom % 3;
        if (op == 0) begin
          d = rline();
          do_req(1, 1, waddr(3, s), 32'hFFFF_FFFF, d, rd, lat, nm);
          wgold[3][s] = d; wvalid[3][s] = 1'b1;
        end else if (op == 1 && wvalid[3][s]) begin
          do_req(0, 1, waddr(3, s), '0, '0, rd, lat, nm);
          chk("R7 reserved way untouched", rd, wgold[3][s]);
          chk("R5 window never uses memory", nm, 0);
        end else if (wvalid[3][s]) begin
          do_req(1, 1, waddr(3, s), 32'h7FFF_FFFF, rline(), rd, lat, nm);
          do_req(0, 1, waddr(3, s), '0, '0, rd, lat, nm);
          chk("R6 partial window write dropped", rd, wgold[3][s]);
        end
      end
    end
    chk("R6 err stays set", err_sticky, 1);

    // R8: reserve everything, flush must write back every dirty line
    cfg_way_mem = 4'b1111;
    do_req(0, 0, waddr(3, 5), '0, '0, rd, lat, nm);
    chk("R7 window kept across reconfiguration", rd, wgold[3][5]);
    begin
      int bad = 0;
      for (int i = 0; i < 128; i++) if (mm[i] !== gold[i]) bad++;
      chk("R8 dirty lines written back", bad, 0);
    end

    // R9 all ways reserved: every access goes to memory
    do_req(0, 1, caddr(16), '0, '0, rd, lat, nm);
    chk("R9 read data", rd, gold[16]);
    do_req(0, 1, caddr(16), '0, '0, rd, lat, nm);
    chk("R9 repeat read uses memory", nm > 0, 1);

    summary();
  end
endmodule